// File: doc/BRIEF.md
# Serial Character Receiver with Three-Sample Voting

This block turns an asynchronous serial line into parallel characters. A shared 16x oversampling tick, generated elsewhere, paces it. The line passes through a two-flop synchronizer first. A falling edge seen on a tick arms the block to look for a start bit. Each bit is then decided by a majority vote over three samples taken around the centre of its 16-tick period. Because of the vote, a disturbance that covers only one sample does not change the decided value.

Character length can be set at run time from 5 to 8 data bits. A parity bit can be enabled, with either polarity, and one or two stop bits can be selected. Each character ends in exactly one of three one-cycle pulses: a valid pulse with the data word, a parity-error pulse, or a framing-error pulse. A character that ends in an error is dropped. The block has no storage beyond a single character. The configuration inputs are expected to stay stable while a character is being received.

Top module: `serial_char_rx`

## Requirements
- R1: The idle line is high and the start bit is low. Data bits follow the start bit, least significant first. A correct character produces a single-cycle `char_valid` pulse, and `char_data` holds that character from the same cycle on.
- R2: `len_sel` sets the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. Output bits above the selected length are 0.
- R3: When `par_en` is 1, one parity bit follows the data. With `par_odd` at 0 the count of ones over the data and the parity bit must be even; with `par_odd` at 1 it must be odd. A mismatch gives a one-cycle `par_err` pulse, and no `char_valid` pulse is produced for that character.
- R4: When `par_en` is 0, no parity bit is expected, `par_odd` has no effect, and `par_err` never rises.
- R5: A stop bit decided low gives a one-cycle `frame_err` pulse and drops the character. With `two_stop` at 1, both stop bits must be high. If the parity is wrong and the first stop bit is also low, only `par_err` is raised.
- R6: Each bit takes the majority of three samples, taken on ticks 7, 8 and 9 of its 16-tick period. A one-tick disturbance near the centre of a bit does not change the received character.
- R7: If a falling edge arms the receiver but the vote on the start bit gives high, the receiver returns to idle and raises no pulse. The next character is still received correctly.
- R8: While `rx_en` is 0, the receiver stays idle and raises no pulse, whatever is on the line.
- R9: After reset all three pulse outputs and `char_data` are 0. At most one of `char_valid`, `par_err` and `frame_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| os_tick | input | 1 | Single-cycle strobe, 16 per bit period |
| rx_serial | input | 1 | Asynchronous serial input |
| rx_en | input | 1 | Enables reception |
| len_sel | input | 2 | Data length code (0 to 3 selects 5 to 8 bits) |
| par_en | input | 1 | A parity bit is present |
| par_odd | input | 1 | Parity polarity, 1 selects odd |
| two_stop | input | 1 | Two stop bits are expected |
| char_data | output | DATA_W | Last correctly received character, zero-extended |
| char_valid | output | 1 | One-cycle pulse for a correct character |
| par_err | output | 1 | One-cycle pulse for a parity mismatch |
| frame_err | output | 1 | One-cycle pulse for a low stop bit |

## Verification
The bench builds the block with its defaults: 8-bit words, 16 ticks per bit, the vote centred on tick 8, and two synchronizer stages. It drives one tick every four clocks, so one bit lasts 64 clocks. With these values all four length codes and every combination of parity and stop bits can be reached within a short run. Because the tick is so coarse, a four-clock disturbance placed mid-bit covers exactly one vote sample. This lets the bench place disturbances on start, data and stop bits and check that the vote absorbs them. An eight-clock low pulse on an idle line tests the rejection of a false start.

// File: rtl/rx_pkg.sv
`timescale 1ns/1ps
package rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;
endpackage

// File: rtl/rx_rst_sync.sv
`timescale 1ns/1ps
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d_in;
    if (i == 0) begin : g_first
      assign d_in = din;
    end else begin : g_next
      assign d_in = ff_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q[i] <= 1'b1;
      else        ff_q[i] <= d_in;
    end
  end

  assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/rx_sampler.sv
`timescale 1ns/1ps
module rx_sampler #(
  parameter int OVS     = 16,
  parameter int SMP_MID = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic restart,
  input  logic run,
  output logic vote_stb,
  output logic vote_bit
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_A    = PW'(SMP_MID - 1);
  localparam logic [PW-1:0] PH_B    = PW'(SMP_MID);
  localparam logic [PW-1:0] PH_C    = PW'(SMP_MID + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          smp_a_q, smp_a_d;
  logic          smp_b_q, smp_b_d;
  logic          adv;

  always_comb begin
    adv     = run && tick && !restart;
    phase_d = phase_q;
    if (restart)  phase_d = '0;
    else if (adv) phase_d = (phase_q == PH_LAST) ? '0 : phase_q + PW'(1);
    smp_a_d  = (adv && phase_d == PH_A) ? line : smp_a_q;
    smp_b_d  = (adv && phase_d == PH_B) ? line : smp_b_q;
    vote_stb = adv && (phase_d == PH_C);
    vote_bit = (smp_a_q & smp_b_q) | (smp_a_q & line) | (smp_b_q & line);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
      smp_a_q <= smp_a_d;
      smp_b_q <= smp_b_d;
    end
  end
endmodule

// File: rtl/rx_ctrl.sv
`timescale 1ns/1ps
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          rx_en,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          two_stop,
  input  logic          vote_stb,
  input  logic          vote_bit,
  output logic          restart,
  output logic          run,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int MIN_BITS = DW - 3;
  localparam int CW       = $clog2(DW);

  rx_state_e     state_q, state_d;
  logic          prev_q, prev_d;
  logic [DW-1:0] shreg_q, shreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          par_q, par_d;
  logic          pbad_q, pbad_d;
  logic [DW-1:0] data_q, data_d;
  logic          valid_q, valid_d, perr_q, perr_d, ferr_q, ferr_d;
  logic [CW-1:0] last_idx, shift_amt;
  logic [DW-1:0] aligned;

  always_comb begin
    last_idx  = CW'(MIN_BITS - 1) + CW'(len_sel);
    shift_amt = CW'(DW - MIN_BITS) - CW'(len_sel);
    aligned   = shreg_q >> shift_amt;
    restart   = rx_en && tick && prev_q && !line && (state_q == RX_IDLE);
    run       = (state_q != RX_IDLE);
    prev_d    = tick ? line : prev_q;

    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    par_d   = par_q;
    pbad_d  = pbad_q;
    data_d  = data_q;
    valid_d = 1'b0;
    perr_d  = 1'b0;
    ferr_d  = 1'b0;

    unique case (state_q)
      RX_IDLE: if (restart) state_d = RX_START;
      RX_START: if (vote_stb) begin
        if (vote_bit) state_d = RX_IDLE;
        else begin
          state_d = RX_DATA;
          cnt_d   = '0;
          par_d   = 1'b0;
          pbad_d  = 1'b0;
        end
      end
      RX_DATA: if (vote_stb) begin
        shreg_d = {vote_bit, shreg_q[DW-1:1]};
        par_d   = par_q ^ vote_bit;
        cnt_d   = cnt_q + CW'(1);
        if (cnt_q == last_idx) state_d = par_en ? RX_PAR : RX_STOP1;
      end
      RX_PAR: if (vote_stb) begin
        pbad_d  = ((par_q ^ vote_bit) != par_odd);
        state_d = RX_STOP1;
      end
      RX_STOP1: if (vote_stb) begin
        state_d = RX_IDLE;
        if (pbad_q)        perr_d = 1'b1;
        else if (!vote_bit) ferr_d = 1'b1;
        else if (two_stop)  state_d = RX_STOP2;
        else begin
          valid_d = 1'b1;
          data_d  = aligned;
        end
      end
      RX_STOP2: if (vote_stb) begin
        state_d = RX_IDLE;
        if (!vote_bit) ferr_d = 1'b1;
        else begin
          valid_d = 1'b1;
          data_d  = aligned;
        end
      end
      default: state_d = RX_IDLE;
    endcase

    if (!rx_en) begin
      state_d = RX_IDLE;
      valid_d = 1'b0;
      perr_d  = 1'b0;
      ferr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      prev_q  <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
      par_q   <= 1'b0;
      pbad_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      prev_q  <= prev_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      par_q   <= par_d;
      pbad_q  <= pbad_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;
endmodule

// File: rtl/serial_char_rx.sv
`timescale 1ns/1ps
module serial_char_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SMP_MID     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              os_tick,
  input  logic              rx_serial,
  input  logic              rx_en,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic [DATA_W-1:0] char_data,
  output logic              char_valid,
  output logic              par_err,
  output logic              frame_err
);
  logic rst_n;
  logic line_s;
  logic restart, run;
  logic vote_stb, vote_bit;

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_serial), .dout(line_s)
  );

  rx_sampler #(.OVS(OVS), .SMP_MID(SMP_MID)) u_smp (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
    .restart(restart), .run(run),
    .vote_stb(vote_stb), .vote_bit(vote_bit)
  );

  rx_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
    .rx_en(rx_en), .len_sel(len_sel), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop),
    .vote_stb(vote_stb), .vote_bit(vote_bit),
    .restart(restart), .run(run),
    .data_o(char_data), .valid_o(char_valid),
    .perr_o(par_err), .ferr_o(frame_err)
  );
endmodule

// File: rtl/serial_char_rx_chk.sv
`timescale 1ns/1ps
module serial_char_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              arst_n,
  input logic              rx_en,
  input logic [1:0]        len_sel,
  input logic              par_en,
  input logic [DATA_W-1:0] char_data,
  input logic              char_valid,
  input logic              par_err,
  input logic              frame_err
);
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({char_valid, par_err, frame_err})); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    char_valid |=> !char_valid); // R1
  AST_PERR_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    par_err |=> !par_err); // R3
  AST_FERR_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    frame_err |=> !frame_err); // R5
  AST_NO_PERR_UNPARITY: assert property (@(posedge clk) disable iff (!arst_n)
    par_err |-> par_en); // R4
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    (char_valid && len_sel == 2'd0) |-> ((char_data >> (DATA_W - 3)) == '0)); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!arst_n)
    $past(!rx_en) |-> !(char_valid || par_err || frame_err)); // R8
endmodule

bind serial_char_rx serial_char_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .rx_en(rx_en), .len_sel(len_sel),
  .par_en(par_en), .char_data(char_data), .char_valid(char_valid),
  .par_err(par_err), .frame_err(frame_err)
);

// File: tb/serial_char_rx_test.sv
`timescale 1ns/1ps
module serial_char_rx_test;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic [1:0] tcnt;
  logic       os_tick;
  logic       rx_serial = 1'b1;
  logic       rx_en = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic [7:0] char_data;
  logic       char_valid, par_err, frame_err;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk or negedge arst_n)
    if (!arst_n) tcnt <= 2'd0; else tcnt <= tcnt + 2'd1;
  assign os_tick = (tcnt == 2'd3);

  serial_char_rx uut (
    .clk(clk), .arst_n(arst_n), .os_tick(os_tick), .rx_serial(rx_serial),
    .rx_en(rx_en), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .char_data(char_data), .char_valid(char_valid),
    .par_err(par_err), .frame_err(frame_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: integers and a bit log, evaluated once per clock
  int m_s1, m_s2, m_prev, m_act, m_ph, m_pos, m_a, m_b;
  logic [15:0] m_bits;
  int e_valid, e_perr, e_ferr, e_data;
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_act = 0; m_ph = 0; m_pos = 0;
      m_a = 1; m_b = 1; m_bits = '0;
      e_valid = 0; e_perr = 0; e_ferr = 0; e_data = 0;
    end else begin
      int line, nd, np, v, ones, d;
      line = m_s2; m_s2 = m_s1; m_s1 = int'(rx_serial);
      e_valid = 0; e_perr = 0; e_ferr = 0;
      nd = 5 + int'(len_sel); np = int'(par_en);
      if (!rx_en) m_act = 0;
      else if (m_act == 0) begin
        if (os_tick && m_prev == 1 && line == 0) begin
          m_act = 1; m_ph = 0; m_pos = 0;
        end
      end else if (os_tick) begin
        m_ph = (m_ph + 1) % 16;
        if (m_ph == 7) m_a = line;
        if (m_ph == 8) m_b = line;
        if (m_ph == 9) begin
          v = (m_a + m_b + line >= 2) ? 1 : 0;
          m_bits[m_pos] = v[0];
          d = 0; ones = 0;
          for (int k = 0; k < nd; k++) begin
            d = d | (int'(m_bits[1+k]) << k);
            ones += int'(m_bits[1+k]);
          end
          if (m_pos == 0 && v == 1) m_act = 0;
          else if (m_pos == 1 + nd + np) begin
            m_act = 0;
            if (par_en && (((ones + int'(m_bits[1+nd])) % 2) != int'(par_odd))) e_perr = 1;
            else if (v == 0) e_ferr = 1;
            else if (two_stop) m_act = 1;
            else begin e_valid = 1; e_data = d; end
          end else if (m_pos == 2 + nd + np) begin
            m_act = 0;
            if (v == 0) e_ferr = 1;
            else begin e_valid = 1; e_data = d; end
          end
          m_pos++;
        end
      end
      if (os_tick) m_prev = line;
    end
  end

  int cnt_v = 0, cnt_p = 0, cnt_f = 0;
  always @(negedge clk) begin
    if (arst_n && !done) begin
      chk("R1", "clockwise valid", int'(char_valid), e_valid);
      chk("R3", "clockwise par_err", int'(par_err), e_perr);
      chk("R5", "clockwise frame_err", int'(frame_err), e_ferr);
      chk("R2", "clockwise data", int'(char_data), e_data);
      if (char_valid) cnt_v++;
      if (par_err) cnt_p++;
      if (frame_err) cnt_f++;
    end
  end

  task automatic send_bit(input logic b, input bit glitch);
    rx_serial = b;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (glitch && c == 29) rx_serial = ~b;
      if (glitch && c == 33) rx_serial = b;
    end
  endtask

  task automatic frame(input string req, input logic [7:0] d, input bit flip,
                       input logic st1, input logic st2, input int gbit,
                       input int xv, input int xp, input int xf, input int xd);
    int bv, bp, bf, nd, idx;
    logic p;
    bv = cnt_v; bp = cnt_p; bf = cnt_f;
    nd = 5 + int'(len_sel);
    idx = 0;
    send_bit(1'b0, gbit == idx); idx++;
    p = par_odd ^ flip;
    for (int k = 0; k < nd; k++) begin
      send_bit(d[k], gbit == idx); idx++;
      p = p ^ d[k];
    end
    if (par_en) begin send_bit(p, gbit == idx); idx++; end
    send_bit(st1, gbit == idx); idx++;
    if (two_stop) send_bit(st2, gbit == idx);
    rx_serial = 1'b1;
    repeat (128) @(negedge clk);
    chk(req, "valid count", cnt_v - bv, xv);
    chk(req, "parity error count", cnt_p - bp, xp);
    chk(req, "framing error count", cnt_f - bf, xf);
    if (xv != 0) chk(req, "data", int'(char_data), xd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9", "reset valid", int'(char_valid), 0);
    chk("R9", "reset par_err", int'(par_err), 0);
    chk("R9", "reset frame_err", int'(frame_err), 0);
    chk("R9", "reset data", int'(char_data), 0);
    repeat (64) @(negedge clk);

    // R1: 8 data bits, no parity, one stop bit
    frame("R1", 8'hA5, 0, 1, 1, -1, 1, 0, 0, 8'hA5);
    frame("R1", 8'h3C, 0, 1, 1, -1, 1, 0, 0, 8'h3C);
    frame("R1", 8'h01, 0, 1, 1, -1, 1, 0, 0, 8'h01);

    // R2: shorter lengths zero the upper bits
    len_sel = 2'd0; frame("R2", 8'hFF, 0, 1, 1, -1, 1, 0, 0, 8'h1F);
    len_sel = 2'd1; frame("R2", 8'hEA, 0, 1, 1, -1, 1, 0, 0, 8'h2A);
    len_sel = 2'd2; frame("R2", 8'hD5, 0, 1, 1, -1, 1, 0, 0, 8'h55);
    len_sel = 2'd3;

    // R3: parity polarity and mismatch
    par_en = 1'b1; par_odd = 1'b0;
    frame("R3", 8'h5A, 0, 1, 1, -1, 1, 0, 0, 8'h5A);
    frame("R3", 8'h5B, 1, 1, 1, -1, 0, 1, 0, 0);
    par_odd = 1'b1;
    frame("R3", 8'h5A, 0, 1, 1, -1, 1, 0, 0, 8'h5A);
    frame("R3", 8'h66, 1, 1, 1, -1, 0, 1, 0, 0);
    len_sel = 2'd0;
    frame("R3", 8'h13, 0, 1, 1, -1, 1, 0, 0, 8'h13);
    len_sel = 2'd3;

    // R4: polarity is irrelevant when parity is off
    par_en = 1'b0; par_odd = 1'b1;
    frame("R4", 8'h77, 0, 1, 1, -1, 1, 0, 0, 8'h77);
    par_odd = 1'b0;

    // R5: stop bit checks and priority
    frame("R5", 8'h42, 0, 0, 1, -1, 0, 0, 1, 0);
    two_stop = 1'b1;
    frame("R5", 8'hC3, 0, 1, 1, -1, 1, 0, 0, 8'hC3);
    frame("R5", 8'h24, 0, 1, 0, -1, 0, 0, 1, 0);
    frame("R5", 8'h24, 0, 0, 1, -1, 0, 0, 1, 0);
    two_stop = 1'b0; par_en = 1'b1;
    frame("R5", 8'h99, 1, 0, 1, -1, 0, 1, 0, 0);
    par_en = 1'b0;

    // R6: one-sample disturbances on start, data and stop bits
    frame("R6", 8'h0F, 0, 1, 1, 4, 1, 0, 0, 8'h0F);
    frame("R6", 8'hF0, 0, 1, 1, 0, 1, 0, 0, 8'hF0);
    frame("R6", 8'h81, 0, 1, 1, 9, 1, 0, 0, 8'h81);

    // R7: short low pulse on an idle line is a false start
    begin
      int bv, bp, bf;
      bv = cnt_v; bp = cnt_p; bf = cnt_f;
      rx_serial = 1'b0;
      repeat (8) @(negedge clk);
      rx_serial = 1'b1;
      repeat (256) @(negedge clk);
      chk("R7", "false start valid", cnt_v - bv, 0);
      chk("R7", "false start par_err", cnt_p - bp, 0);
      chk("R7", "false start frame_err", cnt_f - bf, 0);
    end
    frame("R7", 8'h6D, 0, 1, 1, -1, 1, 0, 0, 8'h6D);

    // R8: disabled receiver stays silent, then recovers
    rx_en = 1'b0;
    frame("R8", 8'h55, 0, 1, 1, -1, 0, 0, 0, 0);
    frame("R8", 8'h12, 0, 0, 1, -1, 0, 0, 0, 0);
    chk("R8", "data kept while disabled", int'(char_data), 8'h6D);
    rx_en = 1'b1;
    repeat (64) @(negedge clk);
    frame("R8", 8'hB2, 0, 1, 1, -1, 1, 0, 0, 8'hB2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule